// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address space mapped through a two-level table structure. The requester presents a virtual address, the access kind (read or write), a large-page enable and the physical base of the directory, then pulses `start`. The walker fetches the directory entry and, for an ordinary 4 KB mapping, the table entry. It does this over a single-outstanding request/acknowledge memory port. On the way it writes back updated accessed and dirty flags. It finishes with a one-cycle `done` pulse, which carries a physical page number and the combined user and writable permissions, or with a one-cycle `fault` pulse.

A directory entry can also map a 4 MB region directly. In that case eight spare bits of the entry extend the physical address beyond 32 bits, giving a physical page number of up to 28 bits. Write permission is withheld from any result whose leaf is not yet dirty. A later write therefore misses again, and the new walk marks the page dirty. Privilege checks and translation storage belong to the requester.

Top module: `pgwalk_top`

## Requirements
- R1: After `start` is accepted, the first memory access is a read at `{dir_base[31:12], va[31:22], 2'b00}`.
- R2: For a directory entry that is not a leaf, the table entry is read at `{dir_entry[31:12], va[21:12], 2'b00}`, and the returned page number is `table_entry[31:12]` with zeros above it.
- R3: An entry with bit 0 clear, at either level, ends the walk with `fault` high, `fault_rsvd` low and `fault_va` equal to the walked address. No write follows.
- R4: When `large_en` is high, a directory entry with bit 7 set is a leaf and no table read follows. The page number is `{entry[20:13], entry[31:22], va[21:12]}` and `page_large` is high. When `large_en` is low, bit 7 has no effect and the entry is used as a pointer.
- R5: A large-page leaf with bit 21 set ends the walk with `fault` and `fault_rsvd` high.
- R6: A directory pointer entry with bit 5 (accessed) clear is written back to its own address with bit 5 set, before the table read. A pointer that already has bit 5 set is not written.
- R7: At the leaf, bit 5 is set and, on a write walk, bit 6 (dirty) is also set. The leaf is written back only if this changes its value.
- R8: `perm_user` is the AND of bit 2 across the levels walked. `perm_write` is the AND of bit 1 across those levels, further ANDed with the leaf's bit 6 after the update.
- R9: `mem_req` is held, and `mem_we`, `mem_addr` and `mem_wdata` stay stable, until `mem_ack`. Only one access is outstanding at a time.
- R10: `busy` is high from the cycle after `start` is accepted until the cycle after the `done` or `fault` pulse. `start` has no effect while `busy` is high.
- R11: `done` and `fault` are never high together, and each is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| va | input | 32 | Virtual address to translate |
| is_write | input | 1 | Walk is for a write access |
| large_en | input | 1 | Allow 4 MB directory leaves |
| dir_base | input | 32 | Physical base of the directory |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Translation ready (one cycle) |
| pa_page | output | PA_W-12 | Physical page number |
| perm_user | output | 1 | Combined user permission |
| perm_write | output | 1 | Combined write permission |
| page_large | output | 1 | Result came from a 4 MB leaf |
| fault | output | 1 | Walk failed (one cycle) |
| fault_va | output | 32 | Address that faulted |
| fault_rsvd | output | 1 | 1 = reserved-bit fault, 0 = not present |

## Verification
The bound checker watches the memory handshake on every cycle. It checks that a request stays stable until acknowledged and that every write-back carries the accessed flag. It checks that the first access after an accepted start targets the directory slot, and that the completion pulses are short and mutually exclusive. Which accesses happen, in what order and with what data only the bench scenarios can show. The same holds for the physical page numbers, the permission results and the fault classification. The bench model predicts these from the memory image for: fresh, accessed and dirty pages; missing entries at both levels; large pages with and without the reserved bit; the large-page bit with large pages disabled; and a start pulsed in the middle of a walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   typedef enum logic [2:0] {
      WK_IDLE,
      WK_RD_DIR,
      WK_WB_DIR,
      WK_RD_TBL,
      WK_WB_TBL,
      WK_DONE,
      WK_FAULT
   } wk_state_t;

   localparam int ENT_W   = 32;
   localparam int F_VALID = 0;
   localparam int F_WR    = 1;
   localparam int F_USR   = 2;
   localparam int F_ACC   = 5;
   localparam int F_DIRTY = 6;
   localparam int F_BIG   = 7;
   localparam int F_RSV   = 21;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int AW       = 32,
   parameter int OFF_W    = 12,
   parameter int IDX_W    = 10,
   parameter int ENT_LOG2 = 2
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] dir_ent,
   input  logic [AW-1:0] vaddr,
   input  logic          sel_tbl,
   output logic [AW-1:0] addr
);
   localparam int DIR_SH = OFF_W + IDX_W;
   localparam logic [AW-1:0] IDX_MASK   = AW'((1 << IDX_W) - 1);
   localparam logic [AW-1:0] FRAME_MASK = ~AW'((1 << OFF_W) - 1);

   logic [AW-1:0] dir_slot, tbl_slot;

   always_comb begin
      dir_slot = (base & FRAME_MASK) | (((vaddr >> DIR_SH) & IDX_MASK) << ENT_LOG2);
      tbl_slot = (dir_ent & FRAME_MASK) | (((vaddr >> OFF_W) & IDX_MASK) << ENT_LOG2);
      addr     = sel_tbl ? tbl_slot : dir_slot;
   end
endmodule

// File: rtl/pgwalk_eval.sv
module pgwalk_eval
   import pgwalk_pkg::*;
#(
   parameter bit LARGE_PAGES = 1'b1
) (
   input  logic [ENT_W-1:0] entry,
   input  logic             at_dir,
   input  logic             large_mode,
   input  logic             wr,
   output logic             present,
   output logic             leaf,
   output logic             rsvd_err,
   output logic             need_wb,
   output logic [ENT_W-1:0] upd
);
   logic big_leaf;

   generate
      if (LARGE_PAGES) begin : g_big
         assign big_leaf = at_dir & large_mode & entry[F_BIG];
      end else begin : g_nobig
         assign big_leaf = 1'b0;
      end
   endgenerate

   always_comb begin
      present  = entry[F_VALID];
      leaf     = at_dir ? big_leaf : 1'b1;
      rsvd_err = big_leaf & entry[F_RSV];
      upd      = entry;
      upd[F_ACC] = 1'b1;
      if (leaf && wr) upd[F_DIRTY] = 1'b1;
      need_wb  = (upd != entry);
   end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int PA_W        = 40,
   parameter bit LARGE_PAGES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [31:0]      va,
   input  logic             is_write,
   input  logic             large_en,
   input  logic [31:0]      dir_base,
   output logic             busy,
   output logic             mem_req,
   output logic             mem_we,
   output logic [31:0]      mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic             mem_ack,
   input  logic [31:0]      mem_rdata,
   output logic             done,
   output logic [PA_W-13:0] pa_page,
   output logic             perm_user,
   output logic             perm_write,
   output logic             page_large,
   output logic             fault,
   output logic [31:0]      fault_va,
   output logic             fault_rsvd
);
   localparam int PG_W  = PA_W - 12;
   localparam int EXT_W = PA_W - 32;

   generate
      if (PA_W < 32 || PA_W > 40) begin : g_bad_pa
         $error("pgwalk_top: PA_W must lie in 32..40");
      end
   endgenerate

   wk_state_t   st;
   logic [31:0] va_q, base_q, dir_q, wb_q;
   logic        wr_q, lg_q, wb_leaf_q;
   logic [PG_W-1:0] pg_q;
   logic        u_q, w_q, big_q, rsvd_q;

   logic        at_dir, at_tbl;
   logic        e_present, e_leaf, e_rsvd, e_wb;
   logic [31:0] e_upd;
   logic [PG_W-1:0] big_pg, small_pg;

   assign at_dir = (st == WK_RD_DIR);
   assign at_tbl = (st == WK_RD_TBL) || (st == WK_WB_TBL);

   pgwalk_addr #(.AW(32), .OFF_W(12), .IDX_W(10), .ENT_LOG2(2)) u_addr (
      .base    (base_q),
      .dir_ent (dir_q),
      .vaddr   (va_q),
      .sel_tbl (at_tbl),
      .addr    (mem_addr)
   );

   pgwalk_eval #(.LARGE_PAGES(LARGE_PAGES)) u_eval (
      .entry      (mem_rdata),
      .at_dir     (at_dir),
      .large_mode (lg_q),
      .wr         (wr_q),
      .present    (e_present),
      .leaf       (e_leaf),
      .rsvd_err   (e_rsvd),
      .need_wb    (e_wb),
      .upd        (e_upd)
   );

   generate
      if (EXT_W > 0) begin : g_ext
         assign big_pg   = {mem_rdata[13 +: EXT_W], mem_rdata[31:22], va_q[21:12]};
         assign small_pg = {{EXT_W{1'b0}}, mem_rdata[31:12]};
      end else begin : g_noext
         assign big_pg   = {mem_rdata[31:22], va_q[21:12]};
         assign small_pg = mem_rdata[31:12];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= WK_IDLE;
         va_q      <= '0;
         base_q    <= '0;
         dir_q     <= '0;
         wb_q      <= '0;
         wr_q      <= 1'b0;
         lg_q      <= 1'b0;
         wb_leaf_q <= 1'b0;
         pg_q      <= '0;
         u_q       <= 1'b0;
         w_q       <= 1'b0;
         big_q     <= 1'b0;
         rsvd_q    <= 1'b0;
      end else begin
         case (st)
            WK_IDLE: if (start) begin
               va_q   <= va;
               base_q <= dir_base;
               wr_q   <= is_write;
               lg_q   <= large_en;
               st     <= WK_RD_DIR;
            end
            WK_RD_DIR: if (mem_ack) begin
               if (!e_present) begin
                  rsvd_q <= 1'b0;
                  st     <= WK_FAULT;
               end else if (e_rsvd) begin
                  rsvd_q <= 1'b1;
                  st     <= WK_FAULT;
               end else if (e_leaf) begin
                  pg_q      <= big_pg;
                  big_q     <= 1'b1;
                  u_q       <= mem_rdata[F_USR];
                  w_q       <= mem_rdata[F_WR] & e_upd[F_DIRTY];
                  wb_q      <= e_upd;
                  wb_leaf_q <= 1'b1;
                  st        <= e_wb ? WK_WB_DIR : WK_DONE;
               end else begin
                  dir_q     <= e_upd;
                  wb_q      <= e_upd;
                  wb_leaf_q <= 1'b0;
                  st        <= e_wb ? WK_WB_DIR : WK_RD_TBL;
               end
            end
            WK_WB_DIR: if (mem_ack) st <= wb_leaf_q ? WK_DONE : WK_RD_TBL;
            WK_RD_TBL: if (mem_ack) begin
               if (!e_present) begin
                  rsvd_q <= 1'b0;
                  st     <= WK_FAULT;
               end else begin
                  pg_q  <= small_pg;
                  big_q <= 1'b0;
                  u_q   <= dir_q[F_USR] & mem_rdata[F_USR];
                  w_q   <= dir_q[F_WR] & mem_rdata[F_WR] & e_upd[F_DIRTY];
                  wb_q  <= e_upd;
                  st    <= e_wb ? WK_WB_TBL : WK_DONE;
               end
            end
            WK_WB_TBL: if (mem_ack) st <= WK_DONE;
            default:   st <= WK_IDLE;
         endcase
      end
   end

   assign busy       = (st != WK_IDLE);
   assign mem_req    = (st == WK_RD_DIR) || (st == WK_WB_DIR) ||
                       (st == WK_RD_TBL) || (st == WK_WB_TBL);
   assign mem_we     = (st == WK_WB_DIR) || (st == WK_WB_TBL);
   assign mem_wdata  = wb_q;
   assign done       = (st == WK_DONE);
   assign fault      = (st == WK_FAULT);
   assign fault_va   = va_q;
   assign fault_rsvd = rsvd_q;
   assign pa_page    = pg_q;
   assign perm_user  = u_q;
   assign perm_write = w_q;
   assign page_large = big_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic [31:0] va,
   input logic [31:0] dir_base,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [31:0] mem_wdata,
   input logic        mem_ack,
   input logic        done,
   input logic        fault
);
   p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));

   p_first_dir_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_req && !mem_we &&
         mem_addr == {$past(dir_base[31:12]), $past(va[31:22]), 2'b00}));

   p_wb_accessed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[5]);

   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_fault_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);

   p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !fault) |=> busy);
endmodule

bind pgwalk_top pgwalk_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .va        (va),
   .dir_base  (dir_base),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .done      (done),
   .fault     (fault)
);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] va = '0;
   logic        is_write = 1'b0;
   logic        large_en = 1'b0;
   logic [31:0] dir_base = '0;
   logic        busy, mem_req, mem_we, done, perm_user, perm_write, page_large;
   logic        fault, fault_rsvd;
   logic [31:0] mem_addr, mem_wdata, fault_va;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [27:0] pa_page;

   always #5 clk = ~clk;

   pgwalk_top uut (
      .clk(clk), .rst_n(rst_n), .start(start), .va(va), .is_write(is_write),
      .large_en(large_en), .dir_base(dir_base), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done(done), .pa_page(pa_page), .perm_user(perm_user),
      .perm_write(perm_write), .page_large(page_large), .fault(fault),
      .fault_va(fault_va), .fault_rsvd(fault_rsvd)
   );

   int total = 0;
   int bad = 0;
   int lat = 0;
   logic [31:0] mem [logic [31:0]];

   bit          xq_we[$];
   logic [31:0] xq_addr[$];
   logic [31:0] xq_data[$];
   string       xq_tag[$];

   bit          x_fault, x_rsvd, x_u, x_w, x_large;
   logic [27:0] x_page;

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'h0;
   endfunction

   function automatic void push(bit we, logic [31:0] a, logic [31:0] d, string tag);
      xq_we.push_back(we);
      xq_addr.push_back(a);
      xq_data.push_back(d);
      xq_tag.push_back(tag);
   endfunction

   // Reference model: predicts the access sequence and outcome from memory.
   function automatic void plan(logic [31:0] v, bit wr, bit lg, logic [31:0] base);
      logic [31:0] da, d, nd, ta, t, nt;
      x_fault = 0; x_rsvd = 0; x_u = 0; x_w = 0; x_large = 0; x_page = '0;
      da = (base & 32'hFFFF_F000) + (v >> 22) * 4;
      d  = rd(da);
      push(0, da, 0, "R1");
      if (d[0] == 0) begin x_fault = 1; return; end
      if (lg && d[7]) begin
         if (d[21]) begin x_fault = 1; x_rsvd = 1; return; end
         nd = d | 32'h20 | (wr ? 32'h40 : 32'h0);
         if (nd != d) push(1, da, nd, "R7");
         x_page  = 28'(((d >> 13) & 32'hFF) << 20) | 28'((d >> 22) << 10) | 28'((v >> 12) & 32'h3FF);
         x_u     = d[2];
         x_w     = d[1] & nd[6];
         x_large = 1;
      end else begin
         if (d[5] == 0) push(1, da, d | 32'h20, "R6");
         ta = (d & 32'hFFFF_F000) + ((v >> 12) & 32'h3FF) * 4;
         t  = rd(ta);
         push(0, ta, 0, "R2");
         if (t[0] == 0) begin x_fault = 1; return; end
         nt = t | 32'h20 | (wr ? 32'h40 : 32'h0);
         if (nt != t) push(1, ta, nt, "R7");
         x_page = 28'(t >> 12);
         x_u    = d[2] & t[2];
         x_w    = d[1] & t[1] & nt[6];
      end
   endfunction

   // Memory responder: compares every access against the model queue.
   initial begin
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (rst_n && mem_req) begin
            repeat (lat) @(negedge clk);
            if (xq_we.size() == 0) begin
               chk(0, "R10", "unexpected access addr", 64'(mem_addr), 64'h0);
            end else begin
               chk(mem_we == xq_we[0], xq_tag[0], "access kind", 64'(mem_we), 64'(xq_we[0]));
               chk(mem_addr == xq_addr[0], xq_tag[0], "access addr", 64'(mem_addr), 64'(xq_addr[0]));
               if (xq_we[0])
                  chk(mem_wdata == xq_data[0], xq_tag[0], "write data", 64'(mem_wdata), 64'(xq_data[0]));
               void'(xq_we.pop_front());
               void'(xq_addr.pop_front());
               void'(xq_data.pop_front());
               void'(xq_tag.pop_front());
            end
            if (mem_we) mem[mem_addr] = mem_wdata;
            else mem_rdata = rd(mem_addr);
            mem_ack = 1'b1;
         end
      end
   end

   task automatic walk(logic [31:0] v, bit wr, bit lg, int l, bit poke, string req);
      int n;
      lat = l;
      plan(v, wr, lg, dir_base);
      @(negedge clk);
      va = v; is_write = wr; large_en = lg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10", "busy after start", 64'(busy), 64'h1);
      n = 0;
      while (!done && !fault && n < 200) begin
         if (poke && n >= 1 && n <= 3) begin
            start = 1'b1; va = 32'h0080_0000; is_write = ~wr;
         end else begin
            start = 1'b0; va = v; is_write = wr;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      chk(fault == x_fault, x_fault ? "R3" : req, "fault", 64'(fault), 64'(x_fault));
      chk(done == !x_fault, req, "done", 64'(done), 64'(!x_fault));
      if (x_fault) begin
         chk(fault_rsvd == x_rsvd, x_rsvd ? "R5" : "R3", "fault kind", 64'(fault_rsvd), 64'(x_rsvd));
         chk(fault_va == v, "R3", "fault address", 64'(fault_va), 64'(v));
      end else begin
         chk(pa_page == x_page, req, "page", 64'(pa_page), 64'(x_page));
         chk(perm_user == x_u, "R8", "user perm", 64'(perm_user), 64'(x_u));
         chk(perm_write == x_w, "R8", "write perm", 64'(perm_write), 64'(x_w));
         chk(page_large == x_large, "R4", "large flag", 64'(page_large), 64'(x_large));
      end
      chk(xq_we.size() == 0, req, "accesses left over", 64'(xq_we.size()), 64'h0);
      @(negedge clk);
      chk(!done && !fault, "R11", "pulse length", 64'({done, fault}), 64'h0);
      chk(!busy, "R10", "idle after finish", 64'(busy), 64'h0);
      repeat (3) begin
         @(negedge clk);
         chk(!mem_req, "R10", "no stray walk", 64'(mem_req), 64'h0);
      end
      xq_we.delete(); xq_addr.delete(); xq_data.delete(); xq_tag.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      dir_base = 32'h0001_0000;
      mem[32'h0001_0004] = 32'h0002_0007;
      mem[32'h0002_000C] = 32'h0055_5007;
      mem[32'h0001_000C] = 32'hFFC0_0087 | (32'hA5 << 13);
      mem[32'h0001_0010] = 32'h0020_0083;
      mem[32'h0001_0014] = 32'h0003_00A3;
      mem[32'h0003_0040] = 32'h0777_7067;
      mem[32'h0001_0018] = 32'h0004_0023;
      mem[32'h0004_0004] = 32'h0088_8005;
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && !done && !fault, "R10", "reset state",
          64'({busy, mem_req, done, fault}), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 R7 R8: fresh 4 KB read, both levels updated, write withheld
      walk(32'h0040_3000, 0, 0, 1, 0, "R2");
      // R7 R8: write marks the leaf dirty, pointer already accessed
      walk(32'h0040_3000, 1, 0, 0, 0, "R7");
      // R7: nothing changes, no write-back
      walk(32'h0040_3000, 0, 1, 2, 0, "R7");
      // R3: missing directory entry
      walk(32'h0080_0000, 0, 0, 0, 0, "R3");
      // R3: missing table entry
      walk(32'h0040_5000, 1, 0, 3, 0, "R3");
      // R4: 4 MB page with extended address bits
      walk(32'h00C1_2345, 0, 1, 1, 0, "R4");
      walk(32'h00C1_2345, 1, 1, 0, 0, "R4");
      // R5: reserved bit in large leaf
      walk(32'h0100_0000, 0, 1, 2, 0, "R5");
      // R4: size bit ignored when large pages are off
      walk(32'h0141_0000, 0, 0, 1, 0, "R4");
      // R8: permissions combined across levels
      walk(32'h0180_1000, 1, 0, 0, 0, "R8");
      // R10: start pulsed during a walk has no effect
      walk(32'h0040_3000, 0, 0, 2, 1, "R10");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule